// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block fronts a small shared word store used by several cores and provides load-linked and store-conditional atomics alongside plain reads and writes. Each cycle every core may present one request. A fixed-priority arbiter grants exactly one of them, and the granted access is applied to the store at the next clock edge. One cycle after the grant, the block returns a response to the winning core.

A load-linked returns the addressed word and places a reservation for the issuing core on that word address. A later store-conditional from the same core writes its data only if that reservation is still intact. The response carries a success flag: 1 when the store was performed and 0 when it was suppressed. Any write to a reserved word by a different core breaks that core's reservation. This covers plain writes and successful conditional stores. Because of this, a read-modify-write bracketed by the pair cannot silently interleave with another writer. Software retries on a 0 flag.

Top module: `llsc_monitor`

## Requirements
- R1: Among cores with `req_valid_i` high, only the lowest-indexed core sees its `gnt_o` bit high in that cycle. A core without a valid request is never granted. With no valid request, `gnt_o` is zero.
- R2: Operation codes are 2'b00 read, 2'b01 write, 2'b10 load-linked and 2'b11 store-conditional. One cycle after a grant, `rsp_valid_o` has the same single bit set. `rsp_rdata_o` holds the word stored at the granted address before that access.
- R3: A granted load-linked returns the addressed word and opens a reservation for the issuing core on that address.
- R4: A store-conditional whose core holds a reservation on the same address writes its data and returns `rsp_sc_ok_o` = 1.
- R5: A store-conditional to an address other than the reserved one, or from a core without a reservation, writes nothing and returns `rsp_sc_ok_o` = 0.
- R6: A granted store-conditional always clears its own core's reservation, so a second one without a new load-linked fails.
- R7: A plain write or a successful store-conditional from one core clears every other core's reservation on that same address. Reservations on other addresses are unaffected.
- R8: A new load-linked replaces the core's earlier reservation, so a store-conditional to the earlier address then fails.
- R9: A granted plain write always updates the word. `rsp_sc_ok_o` is 0 for every operation other than a store-conditional.
- R10: After reset every word reads as zero, no reservation is held and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | NCORE | Request present, one bit per core |
| req_op_i | input | NCORE x 2 | Operation code per core |
| req_addr_i | input | NCORE x AW | Word address per core |
| req_wdata_i | input | NCORE x DW | Write data per core |
| gnt_o | output | NCORE | One-hot grant for the current cycle |
| rsp_valid_o | output | NCORE | Response strobe, one cycle after the grant |
| rsp_rdata_o | output | DW | Word value before the granted access |
| rsp_sc_ok_o | output | 1 | Store-conditional success flag |

## Verification
The hardest case to reach from the ports is a reservation lost to another core's write that lands between a load-linked and the matching store-conditional. This includes the variant where the intervening writer is itself a successful store-conditional. Directed sequences build these interleavings explicitly: reservation, foreign write to the same word, then the conditional store. They also cover writes to a different word and a re-issued load-linked to a new address. A long random phase confines addresses to four words so that collisions, contention among all cores, and stale reservations recur constantly. A behavioural model tracks the store and every reservation and compares grant, data and flag on every cycle.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]    = req_i[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = i[IW-1:0];
    end
  end
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ll_set_i,
  input  logic          sc_own_i,
  input  logic          snoop_we_i,
  input  logic [AW-1:0] addr_i,
  output logic          valid_o,
  output logic          hit_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic          match;

  assign match   = valid_q && (addr_q == addr_i);
  assign valid_o = valid_q;
  assign hit_o   = match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (ll_set_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_i;
    end else if (sc_own_i) begin
      valid_q <= 1'b0;
    end else if (snoop_we_i && match) begin
      valid_q <= 1'b0;
    end
  end

  AST_LL_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ll_set_i |=> valid_o) else $error("ll did not open reservation"); // R3

  AST_SC_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_own_i && !ll_set_i |=> !valid_o) else $error("sc kept reservation"); // R6

  AST_FOREIGN_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_we_i && hit_o && !ll_set_i |=> !valid_o) else $error("foreign write kept reservation"); // R7

  AST_RESV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ll_set_i && !sc_own_i && !(snoop_we_i && hit_o) |=> $stable(valid_o)) else $error("reservation changed"); // R7
endmodule

// File: rtl/llsc_store.sv
module llsc_store #(
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i)) else $error("write lost"); // R4
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 4,
  parameter int DW    = 32,
  localparam int IW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NCORE-1:0]           req_valid_i,
  input  logic [NCORE-1:0][1:0]      req_op_i,
  input  logic [NCORE-1:0][AW-1:0]   req_addr_i,
  input  logic [NCORE-1:0][DW-1:0]   req_wdata_i,
  output logic [NCORE-1:0]           gnt_o,
  output logic [NCORE-1:0]           rsp_valid_o,
  output logic [DW-1:0]              rsp_rdata_o,
  output logic                       rsp_sc_ok_o
);
  logic [NCORE-1:0] win_oh;
  logic [IW-1:0]    win_idx;
  logic             win_any;
  op_e              win_op;
  logic [AW-1:0]    win_addr;
  logic [DW-1:0]    win_wdata;
  logic [NCORE-1:0] slot_valid;
  logic [NCORE-1:0] slot_hit;
  logic             sc_hit;
  logic             is_sc;
  logic             mem_we;
  logic [DW-1:0]    mem_rdata;

  logic [NCORE-1:0] rsp_valid_q;
  logic [DW-1:0]    rsp_rdata_q;
  logic             rsp_ok_q;

  llsc_prio_arb #(.N(NCORE)) u_arb (
    .req_i (req_valid_i),
    .gnt_o (win_oh),
    .idx_o (win_idx),
    .any_o (win_any)
  );

  assign win_op    = op_e'(req_op_i[win_idx]);
  assign win_addr  = req_addr_i[win_idx];
  assign win_wdata = req_wdata_i[win_idx];
  assign is_sc     = win_any && (win_op == OP_SC);
  assign sc_hit    = slot_hit[win_idx];
  assign mem_we    = win_any && ((win_op == OP_WRITE) || ((win_op == OP_SC) && sc_hit));

  for (genvar i = 0; i < NCORE; i++) begin : g_slot
    llsc_resv_slot #(.AW(AW)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .ll_set_i   (win_oh[i] && (win_op == OP_LL)),
      .sc_own_i   (win_oh[i] && (win_op == OP_SC)),
      .snoop_we_i (mem_we && !win_oh[i]),
      .addr_i     (win_addr),
      .valid_o    (slot_valid[i]),
      .hit_o      (slot_hit[i])
    );
  end

  llsc_store #(.AW(AW), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (win_addr),
    .wdata_i (win_wdata),
    .rdata_o (mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= '0;
      rsp_rdata_q <= '0;
      rsp_ok_q    <= 1'b0;
    end else begin
      rsp_valid_q <= win_oh;
      rsp_ok_q    <= is_sc && sc_hit;
      if (win_any) rsp_rdata_q <= mem_rdata;
    end
  end

  assign gnt_o       = win_oh;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;
  assign rsp_sc_ok_o = rsp_ok_q;

  AST_ONE_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)) else $error("multiple grants"); // R1

  AST_GRANT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_valid_i) == '0) else $error("grant without request"); // R1

  AST_LOW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i[0] |-> gnt_o[0]) else $error("core 0 not preferred"); // R1

  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_o) |=> $onehot(rsp_valid_o)) else $error("missing response"); // R2

  AST_OK_SC_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_sc_ok_o |-> $past(is_sc)) else $error("ok flag on non-sc"); // R9

  AST_OK_NEEDS_RESV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sc && !slot_valid[win_idx] |=> !rsp_sc_ok_o) else $error("sc ok without reservation"); // R5
endmodule

// File: tb/tb_llsc_monitor.sv
`timescale 1ns/1ps
module tb_llsc_monitor;
  localparam int NCORE = 4;
  localparam int AW    = 4;
  localparam int DW    = 32;
  localparam int DEPTH = 1 << AW;

  logic                     clk = 1'b0;
  logic                     rst_ni = 1'b0;
  logic [NCORE-1:0]         req_valid;
  logic [NCORE-1:0][1:0]    req_op;
  logic [NCORE-1:0][AW-1:0] req_addr;
  logic [NCORE-1:0][DW-1:0] req_wdata;
  logic [NCORE-1:0]         gnt_o;
  logic [NCORE-1:0]         rsp_valid_o;
  logic [DW-1:0]            rsp_rdata_o;
  logic                     rsp_sc_ok_o;

  always #2 clk = ~clk;

  llsc_monitor #(.NCORE(NCORE), .AW(AW), .DW(DW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .req_op_i    (req_op),
    .req_addr_i  (req_addr),
    .req_wdata_i (req_wdata),
    .gnt_o       (gnt_o),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .rsp_sc_ok_o (rsp_sc_ok_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_rv  [NCORE];
  int            m_ra  [NCORE];
  int            m_nll [NCORE];
  string         m_rsn [NCORE];

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    for (int j = 0; j < NCORE; j++) begin
      m_rv[j] = 0; m_ra[j] = 0; m_nll[j] = 0; m_rsn[j] = "R10";
    end
  endtask

  task automatic clear_others(int w, int a);
    for (int j = 0; j < NCORE; j++)
      if (j != w && m_rv[j] && m_ra[j] == a) begin
        m_rv[j] = 0; m_rsn[j] = "R7";
      end
  endtask

  // Inputs are set just after a falling edge; this steps one full cycle.
  task automatic cycle();
    int w;
    logic [NCORE-1:0] eg;
    logic [DW-1:0] old;
    bit ok;
    string tag;
    int a;
    w = -1;
    #1;
    for (int i = 0; i < NCORE; i++) if (req_valid[i] && w < 0) w = i;
    eg = (w >= 0) ? (NCORE'(1) << w) : '0;
    chk(gnt_o == eg, "R1", "gnt", 64'(gnt_o), 64'(eg));
    ok = 0; old = '0; tag = "R2";
    if (w >= 0) begin
      a = int'(req_addr[w]);
      old = m_mem[a];
      case (req_op[w])
        2'b01: begin tag = "R9"; m_mem[a] = req_wdata[w]; clear_others(w, a); end
        2'b10: begin tag = "R3"; m_rv[w] = 1; m_ra[w] = a; m_nll[w]++; end
        2'b11: begin
          if (m_rv[w] && m_ra[w] == a) begin ok = 1; tag = "R4"; end
          else if (!m_rv[w]) tag = m_rsn[w];
          else tag = (m_nll[w] > 1) ? "R8" : "R5";
          m_rv[w] = 0; m_rsn[w] = "R6"; m_nll[w] = 0;
          if (ok) begin m_mem[a] = req_wdata[w]; clear_others(w, a); end
        end
        default: tag = "R2";
      endcase
    end
    @(posedge clk);
    #1;
    chk(rsp_valid_o == eg, "R2", "rsp_valid", 64'(rsp_valid_o), 64'(eg));
    if (w >= 0) chk(rsp_rdata_o == old, tag, "rdata", 64'(rsp_rdata_o), 64'(old));
    chk(rsp_sc_ok_o == ok, tag, "sc_ok", 64'(rsp_sc_ok_o), 64'(ok));
    @(negedge clk);
  endtask

  task automatic one(int c, logic [1:0] op, int a, logic [DW-1:0] wd);
    req_valid = '0;
    req_valid[c] = 1'b1;
    req_op[c] = op;
    req_addr[c] = AW'(a);
    req_wdata[c] = wd;
    cycle();
    req_valid = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    chk(rsp_valid_o == '0, "R10", "rsp after reset", 64'(rsp_valid_o), 0);
    chk(gnt_o == '0, "R1", "idle gnt", 64'(gnt_o), 0);
    @(negedge clk);

    one(0, 2'b11, 1, 32'h11);          // R10: no reservation after reset
    one(0, 2'b00, 1, 0);               // R10: zero word
    one(1, 2'b01, 1, 32'h5);           // R9
    one(0, 2'b10, 1, 0);               // R3
    one(0, 2'b11, 1, 32'h7);           // R4
    one(2, 2'b00, 1, 0);               // R4 data landed
    one(0, 2'b10, 2, 0);
    one(1, 2'b01, 2, 32'h9);           // R7 foreign plain write
    one(0, 2'b11, 2, 32'hA);
    one(0, 2'b10, 3, 0);
    one(1, 2'b01, 0, 32'h3);           // R7 other address keeps it
    one(0, 2'b11, 3, 32'hB);
    one(0, 2'b10, 1, 0);
    one(0, 2'b10, 2, 0);               // R8 replaces
    one(0, 2'b11, 1, 32'hC);
    one(0, 2'b10, 1, 0);
    one(0, 2'b11, 2, 32'hD);           // R5 address mismatch
    one(1, 2'b10, 0, 0);
    one(2, 2'b10, 0, 0);
    one(1, 2'b11, 0, 32'hE);           // R7 via successful sc
    one(2, 2'b11, 0, 32'hF);
    one(3, 2'b10, 1, 0);
    one(3, 2'b11, 1, 32'h21);
    one(3, 2'b11, 1, 32'h22);          // R6 second sc fails
    one(2, 2'b00, 1, 0);               // R5 failed sc left word

    // R1 contention: all cores at once
    for (int c = 0; c < NCORE; c++) begin
      req_valid[c] = 1'b1; req_op[c] = 2'b10; req_addr[c] = AW'(2); req_wdata[c] = DW'(c);
    end
    cycle();
    req_valid = 4'b1110;
    cycle();
    req_valid = '0;

    for (int n = 0; n < 4000; n++) begin
      for (int c = 0; c < NCORE; c++) begin
        req_valid[c] = ($urandom_range(0, 1) == 1);
        req_op[c]    = 2'($urandom_range(0, 3));
        req_addr[c]  = AW'($urandom_range(0, 3));
        req_wdata[c] = $urandom;
      end
      cycle();
    end
    req_valid = '0;
    cycle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule